// File: doc/BRIEF.md
# Load/Store Port Memory Adapter

This block is a processor-facing load/store port in front of a small byte-addressed memory built from registers. A requester announces one operation at a time with a load or store intent flag, a byte count and an address with a valid flag. It then finishes the operation through a split handshake. The port first raises busy and address-accepted. For a store, the requester then gives a one-cycle data strobe. For a load, the port raises load-valid with the data.

Accesses are 1, 2, 4 or 8 bytes and little-endian. Store data is taken from the low-order bytes of the data input. Load data comes back zero-extended in the low-order bytes of the output. Accesses are expected to be naturally aligned. An address that runs past the end of the memory wraps around modulo the memory size.

Top module: `lsport_mem`

## Requirements
- R1: After reset, busy_o, addr_ack_o and ld_vld_o are low, ld_data_o is zero, and every memory byte reads back as zero.
- R2: While busy_o is low, addr_vld_i high together with st_req_i or ld_req_i high at a rising edge starts an operation. busy_o and addr_ack_o are high from that edge on.
- R3: addr_ack_o is only ever high while busy_o is high. It goes low one cycle after addr_vld_i is seen low during an operation.
- R4: An accepted store commits on the single rising edge where st_vld_i is high. It writes bytes 0..n-1 of st_data_i to addresses addr..addr+n-1, where n is the length. All other memory bytes stay unchanged.
- R5: After the store commit edge, busy_o stays high for one more cycle and is low from the following edge.
- R6: ld_vld_o rises on the second rising edge after the accepting edge of a load. At that point, byte k of ld_data_o holds memory byte addr+k for k < n, and the upper bytes are zero.
- R7: ld_vld_o and ld_data_o hold while ld_req_i stays high. One edge after ld_req_i is seen low, ld_vld_o is low and busy_o is still high. busy_o is low one edge later.
- R8: st_vld_i outside an accepted store does not change memory. addr_vld_i without any intent flag does not start an operation.
- R9: len_i carries the byte count as a plain binary number (1, 2, 4 or 8). Any other code acts as a 1-byte access.
- R10: Two 2-byte stores of values a and b at addresses A and A+2 read back as a 4-byte load at A equal to a | (b << 16).
- R11: If st_req_i and ld_req_i are both high at acceptance, the operation is a store and ld_vld_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| st_req_i | input | 1 | Store intent |
| ld_req_i | input | 1 | Load intent |
| len_i | input | CNT_W (4) | Access length in bytes, binary |
| addr_i | input | ADDR_W (6) | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 8*NBYTES (64) | Store data, low-order bytes used |
| st_vld_i | input | 1 | One-cycle store data strobe |
| ld_data_o | output | 8*NBYTES (64) | Load data, zero-extended |
| ld_vld_o | output | 1 | Load data valid |
| busy_o | output | 1 | Operation in progress |
| addr_ack_o | output | 1 | Address accepted |

## Verification
If the control state were wrong, the handshake outputs would show it within one or two cycles of a request. busy_o would stay high or drop too early. addr_ack_o would appear without busy_o. ld_vld_o would fail to show up on the second edge, or fail to clear after the load intent drops. Errors in lane placement or the byte mask stay hidden until a later load, so every store is read back at its own width and at wider and narrower widths. Neighbouring bytes are read back too, which exposes an over-wide write mask or missing zero-extension in the first load that covers them.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_LDWAIT = 2'd2,
        ST_DONE   = 2'd3
    } lsp_state_e;

endpackage

// File: rtl/lsp_lane.sv
module lsp_lane #(
    parameter int NBYTES = 8,
    localparam int CNT_W = $clog2(NBYTES) + 1
) (
    input  logic [CNT_W-1:0]  cnt,
    output logic [NBYTES-1:0] lane_en
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_en[g] = (CNT_W'(g) < cnt);
    end

endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
    import lsp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 8,
    localparam int CNT_W = $clog2(NBYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req_i,
    input  logic              ld_req_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic              st_vld_i,
    output logic              busy_o,
    output logic              addr_ack_o,
    output logic              ld_vld_o,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  cnt
);

    typedef struct packed {
        lsp_state_e        st;
        logic              is_st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic              ldv;
    } ctl_t;

    ctl_t c_d, c_q;

    function automatic logic [CNT_W-1:0] len_cnt(input logic [CNT_W-1:0] l);
        logic legal;
        legal = (l != '0) && ((l & (l - CNT_W'(1))) == '0) && (l <= CNT_W'(NBYTES));
        return legal ? l : CNT_W'(1);
    endfunction

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (addr_vld_i && (st_req_i || ld_req_i)) begin
                    c_d.st    = ST_ACTIVE;
                    c_d.is_st = st_req_i;
                    c_d.addr  = addr_i;
                    c_d.cnt   = len_cnt(len_i);
                    c_d.ack   = 1'b1;
                end
            end
            ST_ACTIVE: begin
                c_d.ack = c_q.ack && addr_vld_i;
                if (c_q.is_st) begin
                    if (st_vld_i) c_d.st = ST_DONE;
                end else begin
                    c_d.st  = ST_LDWAIT;
                    c_d.ldv = 1'b1;
                end
            end
            ST_LDWAIT: begin
                c_d.ack = c_q.ack && addr_vld_i;
                if (!ld_req_i) begin
                    c_d.st  = ST_DONE;
                    c_d.ldv = 1'b0;
                end
            end
            default: begin
                c_d.ack = 1'b0;
                c_d.ldv = 1'b0;
                c_d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, is_st: 1'b0, addr: '0, cnt: '0, ack: 1'b0, ldv: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o     = (c_q.st != ST_IDLE);
    assign addr_ack_o = c_q.ack;
    assign ld_vld_o   = c_q.ldv;
    assign wr_en      = (c_q.st == ST_ACTIVE) && c_q.is_st && st_vld_i;
    assign rd_en      = (c_q.st == ST_ACTIVE) && !c_q.is_st;
    assign base       = c_q.addr;
    assign cnt        = c_q.cnt;

    // R3
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |-> busy_o);
    // R3
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !addr_vld_i) |=> !addr_ack_o);
    // R4
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R5
    st_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ##2 !busy_o);
    // R6
    ldv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_o |-> busy_o);
    // R7
    ldv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_o && ld_req_i) |=> ld_vld_o);
    // R7
    ldv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_o && !ld_req_i) |=> (!ld_vld_o && busy_o));

endmodule

// File: rtl/lsp_mem.sv
module lsp_mem #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 8,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int DW    = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] base,
    input  logic [NBYTES-1:0] lane_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] bytes;
        logic [DW-1:0]         rdata;
    } mem_t;

    mem_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        for (int j = 0; j < NBYTES; j++) begin
            if (wr_en && lane_en[j]) begin
                m_d.bytes[base + ADDR_W'(j)] = wdata[8*j +: 8];
            end
            if (rd_en) begin
                m_d.rdata[8*j +: 8] = lane_en[j] ? m_q.bytes[base + ADDR_W'(j)] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign rdata = m_q.rdata;

    // R4
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
    // R4
    lane_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> lane_en[0]);

endmodule

// File: rtl/lsport_mem.sv
module lsport_mem #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 8,
    localparam int CNT_W = $clog2(NBYTES) + 1,
    localparam int DW    = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req_i,
    input  logic              ld_req_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [DW-1:0]     st_data_i,
    input  logic              st_vld_i,
    output logic [DW-1:0]     ld_data_o,
    output logic              ld_vld_o,
    output logic              busy_o,
    output logic              addr_ack_o
);

    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [NBYTES-1:0] lane_en;

    lsp_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_req_i   (st_req_i),
        .ld_req_i   (ld_req_i),
        .len_i      (len_i),
        .addr_i     (addr_i),
        .addr_vld_i (addr_vld_i),
        .st_vld_i   (st_vld_i),
        .busy_o     (busy_o),
        .addr_ack_o (addr_ack_o),
        .ld_vld_o   (ld_vld_o),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .base       (base),
        .cnt        (cnt)
    );

    lsp_lane #(.NBYTES(NBYTES)) u_lane (
        .cnt     (cnt),
        .lane_en (lane_en)
    );

    lsp_mem #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .base    (base),
        .lane_en (lane_en),
        .wdata   (st_data_i),
        .rdata   (ld_data_o)
    );

    // R7
    ld_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_o && $past(ld_vld_o)) |-> $stable(ld_data_o));
    // R11
    no_ldv_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ld_vld_o);

endmodule

// File: tb/sim_lsport_mem.sv
module sim_lsport_mem;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req_i = 0, ld_req_i = 0, addr_vld_i = 0, st_vld_i = 0;
    logic [3:0]  len_i = 0;
    logic [5:0]  addr_i = 0;
    logic [63:0] st_data_i = 0;
    logic [63:0] ld_data_o;
    logic        ld_vld_o, busy_o, addr_ack_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsport_mem u0 (
        .clk(clk), .rst_n(rst_n), .st_req_i(st_req_i), .ld_req_i(ld_req_i),
        .len_i(len_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
        .st_data_i(st_data_i), .st_vld_i(st_vld_i), .ld_data_o(ld_data_o),
        .ld_vld_o(ld_vld_o), .busy_o(busy_o), .addr_ack_o(addr_ack_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [3:0] len, input logic [5:0] a,
                            input logic [63:0] d, input logic both);
        while (busy_o) @(negedge clk);
        st_req_i = 1; ld_req_i = both; len_i = len; addr_i = a; addr_vld_i = 1;
        @(negedge clk);
        chk("R2 store ack", {62'd0, busy_o, addr_ack_o}, 64'd3);
        st_data_i = d; st_vld_i = 1;
        @(negedge clk);
        st_vld_i = 0; st_req_i = 0; ld_req_i = 0; addr_vld_i = 0;
        chk("R5 busy after commit", {63'd0, busy_o}, 64'd1);
        chk("R11 no ldv on store", {63'd0, ld_vld_o}, 64'd0);
        @(negedge clk);
        chk("R5 busy released", {63'd0, busy_o}, 64'd0);
    endtask

    task automatic do_load(input logic [3:0] len, input logic [5:0] a,
                           output logic [63:0] d);
        while (busy_o) @(negedge clk);
        ld_req_i = 1; len_i = len; addr_i = a; addr_vld_i = 1;
        @(negedge clk);
        chk("R2 load ack", {61'd0, busy_o, addr_ack_o, ld_vld_o}, 64'd6);
        @(negedge clk);
        chk("R6 ldv second edge", {63'd0, ld_vld_o}, 64'd1);
        d = ld_data_o;
        @(negedge clk);
        chk("R7 ldv held", {63'd0, ld_vld_o}, 64'd1);
        chk("R7 data held", ld_data_o, d);
        ld_req_i = 0; addr_vld_i = 0;
        @(negedge clk);
        chk("R7 ldv drop busy", {62'd0, busy_o, ld_vld_o}, 64'd2);
        @(negedge clk);
        chk("R7 busy low", {63'd0, busy_o}, 64'd0);
    endtask

    // {is_store, len, addr, data, expected}
    localparam int NV = 14;
    localparam logic [140:0] VEC [NV] = '{
        {1'b1, 4'd8, 8'h08, 64'h1122334455667788, 64'h0},
        {1'b0, 4'd8, 8'h08, 64'h0, 64'h1122334455667788},
        {1'b0, 4'd1, 8'h08, 64'h0, 64'h88},
        {1'b0, 4'd1, 8'h0F, 64'h0, 64'h11},
        {1'b0, 4'd2, 8'h0A, 64'h0, 64'h5566},
        {1'b0, 4'd4, 8'h0C, 64'h0, 64'h11223344},
        {1'b1, 4'd1, 8'h09, 64'hFFFFFFFFFFFFFFAB, 64'h0},
        {1'b0, 4'd8, 8'h08, 64'h0, 64'h112233445566AB88},
        {1'b1, 4'd2, 8'h20, 64'hBEEF, 64'h0},
        {1'b1, 4'd2, 8'h22, 64'hCAFE, 64'h0},
        {1'b0, 4'd4, 8'h20, 64'h0, 64'hCAFEBEEF},
        {1'b1, 4'd4, 8'h24, 64'hDEADBEEF12345678, 64'h0},
        {1'b0, 4'd8, 8'h20, 64'h0, 64'h12345678CAFEBEEF},
        {1'b0, 4'd2, 8'h30, 64'h0, 64'h0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outs", {61'd0, busy_o, addr_ack_o, ld_vld_o}, 64'd0);
        chk("R1 reset data", ld_data_o, 64'd0);
        do_load(4'd8, 6'h00, r);
        chk("R1 mem zero", r, 64'd0);

        // R4 R6 R10 table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][140]) begin
                do_store(VEC[i][139:136], VEC[i][133:128], VEC[i][127:64], 1'b0);
            end else begin
                do_load(VEC[i][139:136], VEC[i][133:128], r);
                chk($sformatf("R4 R6 R10 vector %0d", i), r, VEC[i][63:0]);
            end
        end

        // R9 illegal length acts as 1 byte
        do_store(4'd3, 6'h10, 64'hAABBCC, 1'b0);
        do_load(4'd8, 6'h10, r);
        chk("R9 len3 one byte", r, 64'hCC);

        // R8 stray strobe and address without intent
        @(negedge clk);
        addr_vld_i = 1; st_vld_i = 1; st_data_i = 64'hFFFFFFFFFFFFFFFF; addr_i = 6'h10;
        @(negedge clk);
        chk("R8 no start without intent", {62'd0, busy_o, addr_ack_o}, 64'd0);
        addr_vld_i = 0; st_vld_i = 0;
        do_load(4'd8, 6'h10, r);
        chk("R8 memory unchanged", r, 64'hCC);

        // R11 both intents give a store
        do_store(4'd4, 6'h18, 64'h01020304, 1'b1);
        do_load(4'd4, 6'h18, r);
        chk("R11 both intents stored", r, 64'h01020304);

        // R3 ack clears when address valid falls, load valid stays
        ld_req_i = 1; len_i = 4'd2; addr_i = 6'h20; addr_vld_i = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 directed ldv", {63'd0, ld_vld_o}, 64'd1);
        chk("R6 directed data", ld_data_o, 64'hBEEF);
        addr_vld_i = 0;
        @(negedge clk);
        chk("R3 ack cleared", {62'd0, addr_ack_o, ld_vld_o}, 64'd1);
        ld_req_i = 0;
        @(negedge clk);
        chk("R7 ldv cleared", {62'd0, busy_o, ld_vld_o}, 64'd2);
        @(negedge clk);
        chk("R7 idle", {63'd0, busy_o}, 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule